// File: doc/BRIEF.md
# Punched Card Row Reader Sequencer

This block drives a punched-card reader that feeds a data channel with 36-bit words. It holds one card image as 80 column masks of 12 row bits. It turns the image into 24 words, two for each punch row, in row-binary order: the left 36 columns of a row first, then columns 36 to 71.

It also models the reader's mechanics from a millisecond tick:
- the start-up delay;
- the latch point when the motor is already turning;
- the gaps between rows;
- the idle period after a card and the motor shut-off.

It reports end of record, end of file, card errors and attention to the channel. It accepts the channel's accept, end-record and timing-error answers, and a disconnect. A read-select command starts a read. The card images come through a request/valid load port with a two-bit status. A second tick input marks the short delay between the two words of a row.

Top module: `card_row_seq`

## Requirements
- R1: Word p (0..23) takes its bits from punch row p/2. Even p uses columns 0..35, odd p uses columns 36..71. Bit r of column c sits at index c*12+r of `card_img`.
- R2: Inside a word, the highest column of the half lands in bit 0 and the lowest column in bit 35. A card that is read through gives exactly 24 words.
- R3: When a read-select (`cmd_read`=1, `unit_ready`=1) is accepted with the motor stopped, `card_req` rises after the 76th ms tick (75 ms delay plus one service tick).
- R4: When a read-select is accepted while the motor runs idle with 60 ms or less left on the wait, 100 ms is added to the remaining wait. `card_req` then follows the (remaining+101)th ms tick.
- R5: An accepted read-select gives `resp_ok`. A read-select while a command is in progress gives `resp_busy`. Any other command, or a read-select with `unit_ready`=0, gives `resp_nodev` together with `attn`. Each response is a one-cycle pulse in the cycle after the command.
- R6: After an even-indexed word is accepted, the next word appears shortly after the next `short_tick`. After an odd-indexed word, it appears after the 8th ms tick.
- R7: After the 24th word is accepted, `rec_end` pulses after the 8th ms tick. The read request is cleared and an 86 ms wait is loaded.
- R8: When the channel answers a word p with end-record (`chan_resp`=01) or timing-error (10), the rest of the card is skipped. `rec_end` then pulses after 8*(12-p/2)+1 ms ticks.
- R9: A load status of empty (01) or read error (10) pulses `err_flag` and `attn`. End of file (11) pulses `eof_flag` and `attn`. In all three cases the read request is dropped and no word is sent.
- R10: With no read pending, the reader idles for 85 ms and then stops the motor at the next service tick. After end of file it stops at the first service tick.
- R11: A command stays in progress after `rec_end`. If the channel is active when the idle wait passes 30 ms, the next card is requested with no new command.
- R12: A disconnect during a command ends it in the next cycle. It pulses `chan_release`, withdraws any offered word and resets the position, so the next read fetches a new card.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| short_tick | input | 1 | One-cycle pulse marking the short row-half delay |
| cmd_valid | input | 1 | Command strobe |
| cmd_read | input | 1 | 1 = read-select, 0 = any other command |
| unit_ready | input | 1 | A card source is attached |
| resp_ok | output | 1 | Command accepted |
| resp_busy | output | 1 | Command refused, one already in progress |
| resp_nodev | output | 1 | Command refused, no device |
| card_req | output | 1 | Requests the next card image |
| card_valid | input | 1 | Card image and status are valid |
| card_status | input | 2 | 00 ok, 01 empty, 10 read error, 11 end of file |
| card_img | input | 960 | Card image, bit c*12+r = row r of column c |
| word_valid | output | 1 | A word is offered to the channel |
| word_data | output | 36 | Offered word |
| chan_ack | input | 1 | Channel answers the offered word |
| chan_resp | input | 2 | 00 accepted, 01 end record, 10 timing error |
| chan_active | input | 1 | Channel still wants data |
| chan_disc | input | 1 | Channel disconnect |
| chan_release | output | 1 | Pulse: clear the channel's end-record and select state |
| rec_end | output | 1 | Pulse: end of record |
| eof_flag | output | 1 | Pulse: end of file |
| err_flag | output | 1 | Pulse: card error |
| attn | output | 1 | Pulse: attention |
| motor_on | output | 1 | Motor running |
| motor_idle | output | 1 | Motor running with no read pending |
| cmd_busy | output | 1 | A command is in progress |

## Verification
The assertions check the properties that hold in every cycle:
- an offered word stays stable until the channel answers it;
- at most one command response fires at a time;
- a no-device answer carries attention;
- card errors never coincide with data;
- words and card requests only occur with the motor running;
- a disconnect always ends the command in the next cycle;
- the wait never grows except by a load.

The millisecond counts cannot be seen from one cycle, so only the bench scenarios show them. These are the start delay, the latch-point extension, the row gaps, the partial-card skip time, the idle shut-off and the automatic restart. The bench scenarios also cover the bit-gathering of whole random cards.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT,
    ST_SERVE,
    ST_FETCH,
    ST_SEND,
    ST_GAP
  } seq_state_e;

  localparam logic [1:0] CH_ACCEPT = 2'b00;
  localparam logic [1:0] CH_ENDREC = 2'b01;
  localparam logic [1:0] CH_TIMERR = 2'b10;

  localparam logic [1:0] CARD_OK    = 2'b00;
  localparam logic [1:0] CARD_EMPTY = 2'b01;
  localparam logic [1:0] CARD_ERR   = 2'b10;
  localparam logic [1:0] CARD_EOF   = 2'b11;

endpackage

// File: rtl/card_ms_timer.sv
module card_ms_timer #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              dec,
  output logic [WAIT_W-1:0] count
);

  logic [WAIT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/card_row_gather.sv
module card_row_gather #(
  parameter int COLS   = 80,
  parameter int ROWS   = 12,
  parameter int WORD_W = 36,
  parameter int POS_W  = 5
) (
  input  logic [COLS*ROWS-1:0] img,
  input  logic [POS_W-1:0]     pos,
  output logic [WORD_W-1:0]    word
);

  localparam int IMG_BITS = COLS * ROWS;

  int row_sel;
  int half_base;

  always_comb begin
    row_sel   = int'(pos >> 1);
    half_base = pos[0] ? WORD_W : 0;
  end

  for (genvar k = 0; k < WORD_W; k++) begin : g_bit
    int col_k;
    int idx_k;
    always_comb begin
      col_k = half_base + (WORD_W - 1 - k);
      idx_k = col_k * ROWS + row_sel;
      if (row_sel < ROWS && idx_k < IMG_BITS) begin
        word[k] = img[idx_k];
      end else begin
        word[k] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/card_row_seq.sv
module card_row_seq
  import card_seq_pkg::*;
#(
  parameter int COLS        = 80,
  parameter int ROWS        = 12,
  parameter int WORD_W      = 36,
  parameter int WAIT_W      = 8,
  parameter int START_MS    = 75,
  parameter int LATCH_LIM   = 60,
  parameter int LATCH_ADD   = 100,
  parameter int IDLE_MS     = 85,
  parameter int EOR_MS      = 86,
  parameter int ROW_GAP_MS  = 8,
  parameter int RESTART_AT  = 30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ms_tick,
  input  logic                 short_tick,
  input  logic                 cmd_valid,
  input  logic                 cmd_read,
  input  logic                 unit_ready,
  output logic                 resp_ok,
  output logic                 resp_busy,
  output logic                 resp_nodev,
  output logic                 card_req,
  input  logic                 card_valid,
  input  logic [1:0]           card_status,
  input  logic [COLS*ROWS-1:0] card_img,
  output logic                 word_valid,
  output logic [WORD_W-1:0]    word_data,
  input  logic                 chan_ack,
  input  logic [1:0]           chan_resp,
  input  logic                 chan_active,
  input  logic                 chan_disc,
  output logic                 chan_release,
  output logic                 rec_end,
  output logic                 eof_flag,
  output logic                 err_flag,
  output logic                 attn,
  output logic                 motor_on,
  output logic                 motor_idle,
  output logic                 cmd_busy
);

  localparam int              WORDS    = 2 * ROWS;
  localparam int              POS_W    = $clog2(WORDS + 2);
  localparam logic [POS_W-1:0] POS_NEED = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] POS_DONE = POS_W'(WORDS);

  // reset: asynchronous assert, synchronous release
  logic rs_a, rs_b, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a <= 1'b0;
      rs_b <= 1'b0;
    end else begin
      rs_a <= 1'b1;
      rs_b <= rs_a;
    end
  end
  assign rst_q = rs_b;

  seq_state_e       state_q, state_d;
  logic             cmd_q, cmd_d, read_q, read_d;
  logic             on_q, on_d, idle_q, idle_d, eof_q, eof_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             rok_d, rbusy_d, rnodev_d, rel_d, reor_d, reof_d, rerr_d, attn_d;
  logic             rok_q, rbusy_q, rnodev_q, rel_q, reor_q, reof_q, rerr_q, attn_q;
  logic             img_load;
  logic [COLS*ROWS-1:0] img_q;
  logic             t_load, t_dec;
  logic [WAIT_W-1:0] t_val, wait_cnt, skip_ms;

  card_ms_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_q),
    .load     (t_load),
    .load_val (t_val),
    .dec      (t_dec),
    .count    (wait_cnt)
  );

  card_row_gather #(
    .COLS(COLS), .ROWS(ROWS), .WORD_W(WORD_W), .POS_W(POS_W)
  ) u_gather (
    .img  (img_q),
    .pos  (pos_q),
    .word (word_data)
  );

  always_comb begin
    skip_ms = WAIT_W'(ROW_GAP_MS * (ROWS - int'(pos_q >> 1)));
  end

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cmd_d    = cmd_q;
    read_d   = read_q;
    on_d     = on_q;
    idle_d   = idle_q;
    eof_d    = eof_q;
    pos_d    = pos_q;
    rok_d    = 1'b0;
    rbusy_d  = 1'b0;
    rnodev_d = 1'b0;
    rel_d    = 1'b0;
    reor_d   = 1'b0;
    reof_d   = 1'b0;
    rerr_d   = 1'b0;
    attn_d   = 1'b0;
    img_load = 1'b0;
    t_load   = 1'b0;
    t_dec    = 1'b0;
    t_val    = '0;

    unique case (state_q)
      ST_WAIT: begin
        if (ms_tick) begin
          if (wait_cnt != '0) begin
            t_dec = 1'b1;
            if ((wait_cnt == WAIT_W'(RESTART_AT)) && cmd_q && idle_q && on_q &&
                !read_q && chan_active) begin
              read_d = 1'b1;
            end
          end else begin
            state_d = ST_SERVE;
          end
        end
      end
      ST_SERVE: begin
        if (!read_q) begin
          if (eof_q || idle_q) begin
            on_d    = 1'b0;
            idle_d  = 1'b0;
            state_d = ST_OFF;
          end else begin
            idle_d  = 1'b1;
            t_load  = 1'b1;
            t_val   = WAIT_W'(IDLE_MS);
            state_d = ST_WAIT;
          end
        end else begin
          on_d   = 1'b1;
          idle_d = 1'b0;
          if (pos_q == POS_NEED) begin
            state_d = ST_FETCH;
          end else if (pos_q == POS_DONE) begin
            reor_d  = 1'b1;
            read_d  = 1'b0;
            pos_d   = POS_NEED;
            t_load  = 1'b1;
            t_val   = WAIT_W'(EOR_MS);
            state_d = ST_WAIT;
          end else begin
            state_d = ST_SEND;
          end
        end
      end
      ST_FETCH: begin
        if (card_valid) begin
          unique case (card_status)
            CARD_OK: begin
              img_load = 1'b1;
              pos_d    = '0;
              state_d  = ST_SEND;
            end
            CARD_EOF: begin
              reof_d  = 1'b1;
              attn_d  = 1'b1;
              eof_d   = 1'b1;
              read_d  = 1'b0;
              state_d = ST_WAIT;
            end
            default: begin
              rerr_d  = 1'b1;
              attn_d  = 1'b1;
              read_d  = 1'b0;
              state_d = ST_WAIT;
            end
          endcase
        end
      end
      ST_SEND: begin
        if (chan_ack) begin
          if (chan_resp == CH_ACCEPT) begin
            pos_d = pos_q + 1'b1;
            if (!pos_q[0]) begin
              state_d = ST_GAP;
            end else begin
              t_load  = 1'b1;
              t_val   = WAIT_W'(ROW_GAP_MS - 1);
              state_d = ST_WAIT;
            end
          end else begin
            pos_d   = POS_DONE;
            t_load  = 1'b1;
            t_val   = skip_ms;
            state_d = ST_WAIT;
          end
        end
      end
      ST_GAP: begin
        if (short_tick) begin
          state_d = ST_SERVE;
        end
      end
      default: begin
        state_d = state_q;
      end
    endcase

    // command decode
    if (cmd_valid) begin
      if (cmd_read && unit_ready) begin
        if (!cmd_q) begin
          t_load = 1'b1;
          t_dec  = 1'b0;
          if (on_q && idle_q && (wait_cnt <= WAIT_W'(LATCH_LIM))) begin
            t_val = wait_cnt + WAIT_W'(LATCH_ADD);
          end else begin
            t_val = WAIT_W'(START_MS);
          end
          cmd_d   = 1'b1;
          read_d  = 1'b1;
          eof_d   = 1'b0;
          pos_d   = POS_NEED;
          on_d    = on_q;
          idle_d  = idle_q;
          rok_d   = 1'b1;
          state_d = ST_WAIT;
        end else begin
          rbusy_d = 1'b1;
        end
      end else begin
        rnodev_d = 1'b1;
        attn_d   = 1'b1;
      end
    end

    // channel disconnect ends the command
    if (chan_disc && cmd_q) begin
      cmd_d  = 1'b0;
      read_d = 1'b0;
      pos_d  = POS_NEED;
      rel_d  = 1'b1;
      if (state_d == ST_SEND || state_d == ST_FETCH || state_d == ST_GAP) begin
        state_d = ST_WAIT;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q  <= ST_OFF;
      cmd_q    <= 1'b0;
      read_q   <= 1'b0;
      on_q     <= 1'b0;
      idle_q   <= 1'b0;
      eof_q    <= 1'b0;
      pos_q    <= POS_NEED;
      rok_q    <= 1'b0;
      rbusy_q  <= 1'b0;
      rnodev_q <= 1'b0;
      rel_q    <= 1'b0;
      reor_q   <= 1'b0;
      reof_q   <= 1'b0;
      rerr_q   <= 1'b0;
      attn_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      cmd_q    <= cmd_d;
      read_q   <= read_d;
      on_q     <= on_d;
      idle_q   <= idle_d;
      eof_q    <= eof_d;
      pos_q    <= pos_d;
      rok_q    <= rok_d;
      rbusy_q  <= rbusy_d;
      rnodev_q <= rnodev_d;
      rel_q    <= rel_d;
      reor_q   <= reor_d;
      reof_q   <= reof_d;
      rerr_q   <= rerr_d;
      attn_q   <= attn_d;
    end
  end

  // card image store, data only, written on load
  always_ff @(posedge clk) begin
    if (img_load) begin
      img_q <= card_img;
    end
  end

  assign resp_ok      = rok_q;
  assign resp_busy    = rbusy_q;
  assign resp_nodev   = rnodev_q;
  assign chan_release = rel_q;
  assign rec_end      = reor_q;
  assign eof_flag     = reof_q;
  assign err_flag     = rerr_q;
  assign attn         = attn_q;
  assign motor_on     = on_q;
  assign motor_idle   = idle_q;
  assign cmd_busy     = cmd_q;
  assign card_req     = (state_q == ST_FETCH);
  assign word_valid   = (state_q == ST_SEND);

  // checks next to the logic they guard
  assert_word_hold_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (word_valid && !chan_ack && !chan_disc) |=> (word_valid && $stable(word_data)));

  assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_q)
    word_valid |-> (pos_q < POS_DONE));

  assert_resp_single_R5: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({resp_ok, resp_busy, resp_nodev}));

  assert_nodev_attn_R5: assert property (@(posedge clk) disable iff (!rst_q)
    resp_nodev |-> attn);

  assert_wait_no_grow_R7: assert property (@(posedge clk) disable iff (!rst_q)
    !t_load |=> (wait_cnt <= $past(wait_cnt)));

  assert_fail_no_data_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (err_flag || eof_flag) |-> (attn && !word_valid && !card_req && !rec_end));

  assert_motor_run_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (word_valid || card_req) |-> (motor_on && !motor_idle));

  assert_disc_ends_R12: assert property (@(posedge clk) disable iff (!rst_q)
    (chan_disc && cmd_busy) |=> (!cmd_busy && chan_release && !word_valid));

endmodule

// File: tb/card_row_seq_bench.sv
module card_row_seq_bench;

  localparam int COLS = 80;
  localparam int ROWS = 12;
  localparam int WW   = 36;

  logic clk = 1'b0;
  logic rst_n;
  logic ms_tick, short_tick;
  logic cmd_valid, cmd_read, unit_ready;
  logic resp_ok, resp_busy, resp_nodev;
  logic card_req, card_valid;
  logic [1:0] card_status;
  logic [COLS*ROWS-1:0] card_img;
  logic word_valid;
  logic [WW-1:0] word_data;
  logic chan_ack;
  logic [1:0] chan_resp;
  logic chan_active, chan_disc, chan_release;
  logic rec_end, eof_flag, err_flag, attn, motor_on, motor_idle, cmd_busy;

  int total = 0;
  int bad = 0;
  int ms_ph = 0;
  int sh_ph = 0;
  int ticks = 0;
  int cyc = 0;
  int t0, c0, t_cmd, t_rec;
  bit done = 0;

  always #5 clk = ~clk;

  card_row_seq u_card_row_seq (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .short_tick(short_tick),
    .cmd_valid(cmd_valid), .cmd_read(cmd_read), .unit_ready(unit_ready),
    .resp_ok(resp_ok), .resp_busy(resp_busy), .resp_nodev(resp_nodev),
    .card_req(card_req), .card_valid(card_valid), .card_status(card_status),
    .card_img(card_img), .word_valid(word_valid), .word_data(word_data),
    .chan_ack(chan_ack), .chan_resp(chan_resp), .chan_active(chan_active),
    .chan_disc(chan_disc), .chan_release(chan_release), .rec_end(rec_end),
    .eof_flag(eof_flag), .err_flag(err_flag), .attn(attn),
    .motor_on(motor_on), .motor_idle(motor_idle), .cmd_busy(cmd_busy)
  );

  assign ms_tick    = rst_n && (ms_ph == 4);
  assign short_tick = (sh_ph == 2);

  initial begin
    forever begin
      @(posedge clk);
      ms_ph <= (ms_ph == 4) ? 0 : ms_ph + 1;
      sh_ph <= (sh_ph == 2) ? 0 : sh_ph + 1;
      cyc   <= cyc + 1;
      if (ms_tick) ticks <= ticks + 1;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] exp_word(input int p);
    logic [WW-1:0] w;
    for (int k = 0; k < WW; k++) begin
      w[k] = card_img[((p % 2) * WW + WW - 1 - k) * ROWS + p / 2];
    end
    return w;
  endfunction

  task automatic issue(input logic rd, input logic pres);
    @(negedge clk);
    while (ms_tick) @(negedge clk);
    cmd_valid = 1'b1; cmd_read = rd; unit_ready = pres;
    t_cmd = ticks;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic disconnect();
    @(negedge clk);
    chan_disc = 1'b1;
    @(negedge clk);
    chan_disc = 1'b0;
  endtask

  task automatic await_card(input string tag, input int exp_ticks);
    do @(negedge clk); while (!card_req);
    chk(tag, ticks - t_cmd, exp_ticks);
  endtask

  task automatic supply(input logic [1:0] st);
    for (int i = 0; i < COLS * ROWS / 32; i++) card_img[i*32 +: 32] = $urandom;
    card_status = st;
    card_valid  = 1'b1;
    @(negedge clk);
    card_valid  = 1'b0;
  endtask

  // kind: 0 read all, 1 end-record, 2 timing error, 3 disconnect at stop_p
  task automatic run_words(input int stop_p, input int kind);
    int p;
    p = 0;
    forever begin
      while (!word_valid) @(negedge clk);
      if (p > 0) begin
        if ((p - 1) % 2 == 1) chk("R6 odd gap ms ticks", ticks - t0, 8);
        else chk("R6 even gap short", ((cyc - c0) <= 6) ? 1 : 0, 1);
      end
      chk($sformatf("R1 R2 word %0d", p), word_data, exp_word(p));
      repeat ($urandom % 3) @(negedge clk);
      while (ms_tick) @(negedge clk);
      if (kind == 3 && p == stop_p) begin
        chan_disc = 1'b1;
        @(negedge clk);
        chan_disc = 1'b0;
        return;
      end
      chan_ack  = 1'b1;
      chan_resp = (kind != 0 && p == stop_p) ? 2'(kind) : 2'b00;
      t0 = ticks; c0 = cyc;
      @(negedge clk);
      chan_ack = 1'b0;
      if (kind != 0 && p == stop_p) break;
      p++;
      if (p == 2 * ROWS) break;
    end
    do @(negedge clk); while (!rec_end);
    t_rec = ticks;
    if (kind == 0) begin
      chk("R2 words per card", p, 24);
      chk("R7 end record after last word", ticks - t0, 8);
    end else begin
      chk("R8 skip wait", ticks - t0, 8 * (12 - stop_p / 2) + 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int sp;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    cmd_valid = 0; cmd_read = 0; unit_ready = 0;
    card_valid = 0; card_status = 0; card_img = '0;
    chan_ack = 0; chan_resp = 0; chan_active = 0; chan_disc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 reset motor off", motor_on, 0);
    chk("R12 reset no command", cmd_busy, 0);
    chk("R1 reset no word", word_valid, 0);

    // R5 command responses
    issue(1'b0, 1'b1);
    chk("R5 other cmd nodev", resp_nodev, 1);
    chk("R5 other cmd attn", attn, 1);
    issue(1'b1, 1'b0);
    chk("R5 no source nodev", resp_nodev, 1);
    chk("R5 no source busy flag", cmd_busy, 0);
    issue(1'b1, 1'b1);
    chk("R5 read ok", resp_ok, 1);
    chk("R5 busy after read", cmd_busy, 1);
    t0 = t_cmd;
    issue(1'b1, 1'b1);
    chk("R5 second read busy", resp_busy, 1);
    t_cmd = t0;

    // R3 cold start, whole card
    await_card("R3 cold start delay", 76);
    supply(2'b00);
    chan_active = 1'b1;
    run_words(0, 0);

    // R11 automatic restart, then early end record at word 5
    do @(negedge clk); while (!card_req);
    chk("R11 restart ticks", ticks - t_rec, 173);
    chan_active = 1'b0;
    supply(2'b00);
    run_words(5, 1);

    // R12 disconnect while idle, R4 latch point
    while (ticks < t_rec + 10) @(negedge clk);
    disconnect();
    chk("R12 release pulse", chan_release, 1);
    chk("R12 command ended", cmd_busy, 0);
    while (ticks < t_rec + 117) @(negedge clk);
    issue(1'b1, 1'b1);
    chk("R4 read ok", resp_ok, 1);
    await_card("R4 latch point delay", 156);
    supply(2'b00);
    run_words(3, 3);
    t0 = ticks;
    chk("R12 word withdrawn", word_valid, 0);
    chk("R12 command ended mid card", cmd_busy, 0);
    chk("R12 release mid card", chan_release, 1);
    do @(negedge clk); while (motor_on);
    chk("R10 idle shut off", ticks - t0, 87);

    // R12 new read fetches a new card, R9 end of file
    issue(1'b1, 1'b1);
    await_card("R12 R3 new card after disconnect", 76);
    supply(2'b11);
    chk("R9 eof flag", eof_flag, 1);
    chk("R9 eof attn", attn, 1);
    chk("R9 eof no word", word_valid, 0);
    t0 = ticks;
    do @(negedge clk); while (motor_on);
    chk("R10 eof shut off", ticks - t0, 1);

    // R9 empty source
    disconnect();
    issue(1'b1, 1'b1);
    await_card("R3 start after eof", 76);
    supply(2'b01);
    chk("R9 empty err flag", err_flag, 1);
    chk("R9 empty attn", attn, 1);
    t0 = ticks;
    repeat (20) @(negedge clk);
    chk("R9 no word after error", word_valid, 0);
    do @(negedge clk); while (motor_on);
    chk("R10 idle after error", ticks - t0, 87);

    // R9 read error, then random timing error position
    disconnect();
    issue(1'b1, 1'b1);
    await_card("R3 start again", 76);
    supply(2'b10);
    chk("R9 read err flag", err_flag, 1);
    disconnect();
    do @(negedge clk); while (motor_on);
    issue(1'b1, 1'b1);
    await_card("R3 start before timing error", 76);
    supply(2'b00);
    sp = $urandom % 24;
    run_words(sp, 2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule